// File: doc/BRIEF.md
# Programmable Interval Timer Channel with Compare

This block is one 16-bit up-counting timer channel behind a small register interface. Software can load the count, program a compare value, and set a mode word. The mode word picks the count source: every system clock, one tick in eight system clocks, or rising edges of an asynchronous external pulse such as a video line strobe. The mode word can also stop counting outright.

On every count step the channel compares the current value with the compare register and with full scale. A match can send the count back to zero, so the channel becomes a periodic divider. Otherwise the count runs to 0xFFFF and rolls over. Either event can request an interrupt. The request is a one-cycle pulse on one chosen bit of an interrupt vector, and it fires either on every event or only on the first event after a mode write.

Three status bits in the mode word record the events. The two event-specific bits clear as a side effect of reading the mode word, so software can poll and acknowledge with a single access.

Top module: `tgt_timer`

## Requirements
- R1: Each enabled count step adds one to the count. A step taken at 0xFFFF sets the count to zero and is a wrap event, unless R2 applies.
- R2: When mode bit 3 is set, a step taken while the count equals the compare value sets the count to zero. This also applies at 0xFFFF, and in that case no wrap event is raised.
- R3: Every step taken while the count equals the compare value is a match event. A match event sets mode bits 11 and 10. A wrap event sets mode bits 12 and 10. Mode bits are read at offset 1.
- R4: A read at offset 1 returns the current mode word. The clock edge that ends the read then clears bits 11 and 12 and keeps bit 10. An event on that same edge sets its bit anyway.
- R5: Mode bit 4 enables interrupts on match events and mode bit 5 enables them on wrap events. An interrupt appears as a one-cycle high on `irq_vec[IRQ_BIT]` (default bit 4) in the cycle after the event.
- R6: When mode bit 6 is set, every enabled event raises an interrupt. When it is clear, only the first enabled event after a mode write raises one.
- R7: A write at offset 1 stores data bits 12:0 as the mode word, and mode bits 15:13 always read as zero. The same write sets the count to zero, re-arms the one-shot interrupt, restarts the divider, and cancels any step or event on that edge.
- R8: A write at offset 0 loads the low 16 bits of the data into the count. A step on that edge is dropped.
- R9: A write at offset 2 changes only the compare value, read back at offset 2. The count is not disturbed.
- R10: Clock source, in order of priority: mode bit 0 stops counting; else mode bit 8 counts rising edges of `ext_tick`, each seen after a two-flop synchronizer; else mode bit 9 counts once per eight clocks, with the first step on the eighth clock after the mode write; else the count steps on every clock.
- R11: Offset 3 reads as zero. After reset the count, mode word, compare value and interrupt output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe, one cycle per access |
| bus_re | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | 2 | Register offset: 0 count, 1 mode, 2 compare, 3 none |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 16 | Read data for the register at `bus_addr`, combinational |
| ext_tick | input | 1 | Asynchronous external count pulse |
| irq_vec | output | 8 | Interrupt vector, only bit `IRQ_BIT` is ever driven high |

## Verification
The hardest situations to reach from the ports are collisions on a single edge: an event against a mode read, and a step against a count or mode write. They matter most near full scale, where wrap and match can compete for the same step. The stimulus therefore loads the count just below 0xFFFF with the compare value placed at 0xFFFF or far away, and it issues mode reads right after the event windows. A behavioural model follows every edge, so each collision is scored in the cycle where it happens. The one-shot and repeat interrupt modes are checked by counting pulses over fixed windows with a short compare period.

// File: rtl/tgt_timer_pkg.sv
package tgt_timer_pkg;

  // mode word layout (stored width and bit roles)
  localparam int unsigned MODE_W      = 13;
  localparam int unsigned MB_HALT     = 0;
  localparam int unsigned MB_TGT_RST  = 3;
  localparam int unsigned MB_IRQ_TGT  = 4;
  localparam int unsigned MB_IRQ_WRAP = 5;
  localparam int unsigned MB_REPEAT   = 6;
  localparam int unsigned MB_EXT      = 8;
  localparam int unsigned MB_DIV      = 9;
  localparam int unsigned MB_ANY_EVT  = 10;
  localparam int unsigned MB_HIT_TGT  = 11;
  localparam int unsigned MB_HIT_WRAP = 12;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_MODE   = 2'd1,
    REG_TARGET = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic halt;
    logic use_ext;
    logic use_div;
  } clk_cfg_t;

endpackage

// File: rtl/tgt_timer_tick_src.sv
module tgt_timer_tick_src
  import tgt_timer_pkg::*;
#(
  parameter int unsigned DIV_LOG2 = 3,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  clk_cfg_t cfg,
  input  logic     ext_in,
  output logic     tick
);

  localparam int unsigned HIST_W = SYNC_LEN + 1;

  logic [HIST_W-1:0] hist_q, hist_n;
  logic              ext_edge;
  logic              div_tick;

  // synchronizer plus one history flop for edge detection
  always_comb begin
    hist_n = {hist_q[HIST_W-2:0], ext_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_n;
  end

  assign ext_edge = hist_q[HIST_W-2] & ~hist_q[HIST_W-1];

  generate
    if (DIV_LOG2 == 0) begin : g_no_div
      assign div_tick = 1'b1;
    end else begin : g_div
      logic [DIV_LOG2-1:0] pre_q, pre_n;

      always_comb begin
        if (restart) pre_n = '0;
        else         pre_n = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_n;
      end

      assign div_tick = &pre_q;

      // divided ticks are never back to back
      assert_div_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> !div_tick);
    end
  endgenerate

  always_comb begin
    if (cfg.halt)         tick = 1'b0;
    else if (cfg.use_ext) tick = ext_edge;
    else if (cfg.use_div) tick = div_tick;
    else                  tick = 1'b1;
  end

  // a held-high external input yields a single edge
  assert_ext_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);

endmodule

// File: rtl/tgt_timer_core.sv
module tgt_timer_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] tgt_val,
  input  logic             tgt_rst,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_tgt,
  output logic             ev_wrap
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;
  logic             hit_tgt;
  logic             at_full;
  logic             step;

  assign hit_tgt = (cnt_q == tgt_val);
  assign at_full = &cnt_q;
  assign step    = tick & ~ld_en & ~restart;

  always_comb begin
    ev_tgt  = step & hit_tgt;
    ev_wrap = step & at_full & ~(tgt_rst & hit_tgt);
  end

  always_comb begin
    cnt_en = restart | ld_en | step;
    cnt_n  = cnt_q;
    if (restart)                cnt_n = '0;
    else if (ld_en)             cnt_n = ld_val;
    else if (tgt_rst & hit_tgt) cnt_n = '0;
    else                        cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);

  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> cnt_q == '0);

  assert_tgt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tgt && tgt_rst |=> cnt_q == '0);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !ld_en && !restart |=> $stable(cnt_q));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && !restart |=> cnt_q == $past(ld_val));

endmodule

// File: rtl/tgt_timer_ctrl.sv
module tgt_timer_ctrl
  import tgt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              wr_tgt,
  input  logic              rd_mode,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              ev_tgt,
  input  logic              ev_wrap,
  output logic [MODE_W-1:0] mode,
  output logic [CNT_W-1:0]  tgt,
  output logic              irq
);

  logic [MODE_W-1:0] mode_q, mode_n;
  logic [CNT_W-1:0]  tgt_q;
  logic              fired_q, fired_n;
  logic              irq_q, irq_n;
  logic              req, fire;

  always_comb begin
    mode_n = mode_q;
    if (wr_mode) begin
      mode_n = wdata[MODE_W-1:0];
    end else begin
      if (rd_mode) begin
        mode_n[MB_HIT_TGT]  = 1'b0;
        mode_n[MB_HIT_WRAP] = 1'b0;
      end
      if (ev_tgt) begin
        mode_n[MB_HIT_TGT] = 1'b1;
        mode_n[MB_ANY_EVT] = 1'b1;
      end
      if (ev_wrap) begin
        mode_n[MB_HIT_WRAP] = 1'b1;
        mode_n[MB_ANY_EVT]  = 1'b1;
      end
    end
  end

  always_comb begin
    req     = (ev_tgt & mode_q[MB_IRQ_TGT]) | (ev_wrap & mode_q[MB_IRQ_WRAP]);
    fire    = req & ~wr_mode & (mode_q[MB_REPEAT] | ~fired_q);
    fired_n = wr_mode ? 1'b0 : (fired_q | fire);
    irq_n   = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      fired_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      fired_q <= fired_n;
      irq_q   <= irq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (wr_tgt) tgt_q <= wdata;
  end

  assign mode = mode_q;
  assign tgt  = tgt_q;
  assign irq  = irq_q;

  assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[MB_REPEAT] && fired_q && !wr_mode |=> !irq_q);

  assert_flag_tgt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tgt && !wr_mode |=> mode_q[MB_HIT_TGT] && mode_q[MB_ANY_EVT]);

  assert_flag_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap && !wr_mode |=> mode_q[MB_HIT_WRAP] && mode_q[MB_ANY_EVT]);

  assert_rd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode && !wr_mode && !ev_tgt && !ev_wrap |=> !mode_q[MB_HIT_TGT] && !mode_q[MB_HIT_WRAP]);

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_tgt && !ev_wrap |=> !irq_q);

endmodule

// File: rtl/tgt_timer.sv
module tgt_timer
  import tgt_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned DIV_LOG2 = 3,
  parameter int unsigned IRQ_W    = 8,
  parameter int unsigned IRQ_BIT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ext_tick,
  output logic [IRQ_W-1:0] irq_vec
);

  localparam int unsigned PAD_W = CNT_W - MODE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  reg_sel_e          sel;
  logic              wr_cnt, wr_mode, wr_tgt, rd_mode;
  logic [MODE_W-1:0] mode;
  logic [CNT_W-1:0]  tgt, cnt;
  logic              tick, ev_tgt, ev_wrap, irq;
  clk_cfg_t          cfg;
  logic              unused_wdata_hi;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_cnt  = bus_we & (sel == REG_COUNT);
  assign wr_mode = bus_we & (sel == REG_MODE);
  assign wr_tgt  = bus_we & (sel == REG_TARGET);
  assign rd_mode = bus_re & (sel == REG_MODE);

  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CNT_W];

  assign cfg.halt    = mode[MB_HALT];
  assign cfg.use_ext = mode[MB_EXT];
  assign cfg.use_div = mode[MB_DIV];

  tgt_timer_tick_src #(.DIV_LOG2(DIV_LOG2), .SYNC_LEN(2)) i_tick_src (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (wr_mode),
    .cfg     (cfg),
    .ext_in  (ext_tick),
    .tick    (tick)
  );

  tgt_timer_core #(.CNT_W(CNT_W)) i_core (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .restart (wr_mode),
    .ld_en   (wr_cnt),
    .ld_val  (bus_wdata[CNT_W-1:0]),
    .tgt_val (tgt),
    .tgt_rst (mode[MB_TGT_RST]),
    .cnt     (cnt),
    .ev_tgt  (ev_tgt),
    .ev_wrap (ev_wrap)
  );

  tgt_timer_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_mode (wr_mode),
    .wr_tgt  (wr_tgt),
    .rd_mode (rd_mode),
    .wdata   (bus_wdata[CNT_W-1:0]),
    .ev_tgt  (ev_tgt),
    .ev_wrap (ev_wrap),
    .mode    (mode),
    .tgt     (tgt),
    .irq     (irq)
  );

  always_comb begin
    unique case (sel)
      REG_COUNT:  bus_rdata = cnt;
      REG_MODE:   bus_rdata = {{PAD_W{1'b0}}, mode};
      REG_TARGET: bus_rdata = tgt;
      default:    bus_rdata = '0;
    endcase
  end

  generate
    for (genvar gi = 0; gi < IRQ_W; gi++) begin : g_irq
      if (gi == IRQ_BIT) begin : g_on
        assign irq_vec[gi] = irq;
      end else begin : g_off
        assign irq_vec[gi] = 1'b0;
      end
    end
  endgenerate

  assert_irq_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(irq_vec));

  assert_mode_hi_zero_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    sel == REG_MODE |-> bus_rdata[CNT_W-1:MODE_W] == '0);

endmodule

// File: tb/test_tgt_timer.sv
`timescale 1ns/1ps
module test_tgt_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we, bus_re;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        ext_tick;
  logic [7:0]  irq_vec;

  int n_chk  = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tgt_timer i_tgt_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .irq_vec(irq_vec)
  );

  // ---------------- behavioural reference ----------------
  int m_cnt = 0, m_mode = 0, m_tgt = 0, m_fired = 0, m_irq = 0;
  int m_divc = 0, m_rel = 0;
  int m_ext[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mode = 0; m_tgt = 0; m_fired = 0; m_irq = 0;
      m_divc = 0; m_rel = 0; m_ext = '{0, 0, 0};
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit tk, wm, wc, wt, rm, et, ew, fire, b3;
      wm = bus_we && bus_addr == 1;
      wc = bus_we && bus_addr == 0;
      wt = bus_we && bus_addr == 2;
      rm = bus_re && bus_addr == 1;
      b3 = m_mode[3];
      if (m_mode[0])      tk = 0;
      else if (m_mode[8]) tk = (m_ext[1] == 1) && (m_ext[0] == 0);
      else if (m_mode[9]) tk = (m_divc == 7);
      else                tk = 1;
      et = tk && !wc && !wm && (m_cnt == m_tgt);
      ew = tk && !wc && !wm && (m_cnt == 'hFFFF) && !(b3 && m_cnt == m_tgt);
      fire = !wm && ((et && m_mode[4]) || (ew && m_mode[5])) && (m_mode[6] || !m_fired);
      if (wm)      m_cnt = 0;
      else if (wc) m_cnt = bus_wdata & 'hFFFF;
      else if (tk) m_cnt = (b3 && m_cnt == m_tgt) ? 0 : (m_cnt + 1) & 'hFFFF;
      if (wm) m_mode = bus_wdata & 'h1FFF;
      else begin
        if (rm) m_mode = m_mode & ~'h1800;
        if (et) m_mode = m_mode | 'h0C00;
        if (ew) m_mode = m_mode | 'h1400;
      end
      m_fired = wm ? 0 : (m_fired | fire);
      m_irq = fire;
      if (wt) m_tgt = bus_wdata & 'hFFFF;
      m_divc = wm ? 0 : (m_divc + 1) & 7;
      m_ext.push_back(int'(ext_tick));
      void'(m_ext.pop_front());
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int exp_rd;
      string tag;
      case (bus_addr)
        2'd0: begin exp_rd = m_cnt;  tag = "R1 count";   end
        2'd1: begin exp_rd = m_mode; tag = "R3 mode";    end
        2'd2: begin exp_rd = m_tgt;  tag = "R9 compare"; end
        default: begin exp_rd = 0;   tag = "R11 empty";  end
      endcase
      chk(tag, int'(bus_rdata), exp_rd);
      chk("R5 irq", int'(irq_vec), m_irq ? 'h10 : 0);
      if (irq_vec != 0) irq_cnt++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(posedge clk); #1;
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    v = int'(bus_rdata);
    @(posedge clk); #1;
    bus_re = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic ext_pulse(input int hi, input int lo);
    @(posedge clk); #1 ext_tick = 1'b1;
    repeat (hi) @(posedge clk);
    #1 ext_tick = 1'b0;
    repeat (lo) @(posedge clk);
  endtask

  initial begin
    int v, base;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = 2'd0;
    bus_wdata = '0; ext_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset count", int'(bus_rdata), 0);
    chk("R11 reset irq", int'(irq_vec), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);

    // repeat interrupts on a period of five
    wr(2'd2, 32'd4);
    wr(2'd1, 32'h0058);
    base = irq_cnt;
    repeat (50) @(posedge clk);
    chk("R6 repeat pulses", irq_cnt - base, 9);

    // one-shot, then re-armed by a mode write
    wr(2'd1, 32'h0018);
    base = irq_cnt;
    repeat (50) @(posedge clk);
    chk("R6 one-shot pulses", irq_cnt - base, 1);
    wr(2'd1, 32'h0018);
    base = irq_cnt;
    repeat (20) @(posedge clk);
    chk("R7 re-arm pulses", irq_cnt - base, 1);

    // wrap near full scale, upper mode bits dropped
    wr(2'd2, 32'h8000);
    wr(2'd1, 32'hE020);
    base = irq_cnt;
    wr(2'd0, 32'hFFFF_FFF0);
    @(negedge clk);
    chk("R8 count load", int'(bus_rdata), 'hFFF0);
    repeat (17) @(posedge clk);
    rd(2'd1, v);
    chk("R3 wrap flags", v, 'h1420);
    rd(2'd1, v);
    chk("R4 read clears", v, 'h0420);
    chk("R5 wrap irq", irq_cnt - base, 1);

    // compare at full scale with reset-on-compare: match wins
    wr(2'd2, 32'hFFFF);
    wr(2'd1, 32'h0038);
    wr(2'd0, 32'hFFFE);
    repeat (6) @(posedge clk);
    rd(2'd1, v);
    chk("R2 match over wrap", v, 'h0C38);

    // divide by eight
    wr(2'd2, 32'h8000);
    wr(2'd1, 32'h0200);
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk("R10 divided count", int'(bus_rdata), 10);

    // halt, load under halt, compare write leaves count
    wr(2'd1, 32'h0001);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R10 halted", int'(bus_rdata), 0);
    wr(2'd0, 32'd5);
    repeat (10) @(posedge clk);
    wr(2'd2, 32'd3);
    @(negedge clk);
    chk("R9 count kept", int'(bus_rdata), 5);
    rd(2'd2, v);
    chk("R9 compare readback", v, 3);
    rd(2'd3, v);
    chk("R11 empty offset", v, 0);

    // external edges
    wr(2'd2, 32'h8000);
    wr(2'd1, 32'h0100);
    for (int i = 0; i < 3; i++) ext_pulse(4, 4);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 ext edges", int'(bus_rdata), 3);
    ext_pulse(20, 6);
    @(negedge clk);
    chk("R10 ext long pulse", int'(bus_rdata), 4);

    // free run across a full wrap under the model
    wr(2'd1, 32'h0020);
    wr(2'd0, 32'hFFF8);
    repeat (40) @(posedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule